// File: doc/BRIEF.md
# Cascaded Systolic FIR Filter

A finite impulse response filter in which every tap is a multiply-accumulate stage. Each stage passes its partial sum straight to the next stage over a dedicated cascade path, so the taps are summed by a linear chain of adders and no adder tree is built. Every tap registers its multiplier operand, registers the raw product, and registers the post-adder result. The sample delay line uses two registers per tap, so the incoming sample and the partial sum reach each tap in step.

The filter advances only on cycles where the input valid is high. With the input valid low, all data registers hold their values. Coefficients are written one tap at a time through a load port while the filter is idle. The synchronous reset clears the valid tracking and the partial sums, but leaves the coefficients and the sample delay line as they are. A parameter removes the operand register stage. When it is removed, that register's clock enable is held low and the multiplier reads the delay-line tap directly, which shortens the latency by one advance. The register after the multiplier is always present.

Top module: `fir_cascade`

## Requirements
- R1: For the cycle after the synchronous reset is released, out_valid is 0 and out_sample is 0.
- R2: Number the advances (cycles with in_valid high) from 0 after reset, with x(t) the sample taken at advance t. In the cycle after advance t, out_sample equals the sum over taps j = 0..NTAPS-1 of c_j·x(t-L-j), where L = NTAPS+1 with the operand stage present. Tap 0 weights the newest sample.
- R3: In a cycle with in_valid low, no advance takes place. out_sample holds its value into the next cycle, and out_valid is 0 in the next cycle.
- R4: out_valid is 1 only in the cycle after an advance t with t ≥ L+NTAPS-1. Earlier results are suppressed because they depend on samples from before reset.
- R5: A write with coef_we=1 and in_valid=0 stores coef_data as the coefficient of tap coef_idx. In the R2 sum, the term for tap j uses the value that coefficient held at advance t-NTAPS+j.
- R6: A coefficient write presented in a cycle with in_valid high is ignored.
- R7: A coefficient write with coef_idx ≥ NTAPS is ignored. The index port is clog2(NTAPS+1) bits wide.
- R8: Reset does not alter the coefficients. After reset, results use the coefficients loaded before it.
- R9: With IN_STAGE=0, the operand register is removed and L = NTAPS. All other rules hold unchanged.
- R10: Products of full-scale signed samples (−32768..32767) and coefficients (−131072..131071) are summed exactly in the 48-bit two's-complement result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the filter advances when high |
| in_sample | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe, honoured only while idle |
| coef_idx | input | clog2(NTAPS+1) | Tap index of the coefficient write |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | High for one cycle when out_sample holds a fresh result |
| out_sample | output | AW | Signed filter output |

## Verification
The assertions assume that reset is held for at least one clock edge before the first sample. They also assume that the coefficient port is driven to known values whenever coef_we is high. The bench starts every phase with reset asserted for several cycles. It drives coef_we, coef_idx and coef_data on every cycle, and it keeps its coefficient and sample values within their signed ranges. Idle gaps are placed between sample bursts so that the hold rules are exercised. Two instances run side by side, one with the operand stage and one without, so that both latencies are checked against the same stimulus.

// File: rtl/fir_cascade.sv
module fir_cascade #(
  parameter int NTAPS    = 4,
  parameter int DW       = 16,
  parameter int CW       = 18,
  parameter int AW       = 48,
  parameter int IN_STAGE = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic signed [DW-1:0]           in_sample,
  input  logic                           coef_we,
  input  logic [$clog2(NTAPS+1)-1:0]     coef_idx,
  input  logic signed [CW-1:0]           coef_data,
  output logic                           out_valid,
  output logic signed [AW-1:0]           out_sample
);
  localparam int IW   = $clog2(NTAPS+1);
  localparam int PW   = DW + CW;
  localparam int LAT  = NTAPS + ((IN_STAGE != 0) ? 1 : 0);
  localparam int FILL = LAT + NTAPS - 1;
  localparam int CNTW = $clog2(FILL + 1);

  logic [NTAPS-1:0][CW-1:0] coef;
  logic [CNTW-1:0]          fill_cnt;
  logic                     ce_in;

  assign ce_in = (IN_STAGE != 0) ? in_valid : 1'b0;

  always_ff @(posedge clk)
    if (coef_we && !in_valid)
      for (int k = 0; k < NTAPS; k++)
        if (coef_idx == IW'(k)) coef[k] <= coef_data;

  always_ff @(posedge clk)
    if (rst) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && (fill_cnt == CNTW'(FILL));
      if (in_valid && fill_cnt != CNTW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
    end

  for (genvar k = 0; k < NTAPS; k++) begin : tap
    logic signed [DW-1:0] xin, d1, d2, a, opnd;
    logic signed [PW-1:0] prod, m;
    logic signed [AW-1:0] pin, p;

    if (k == 0) begin : g_head
      assign xin = in_sample;
      assign pin = '0;
    end else begin : g_link
      assign xin = tap[k-1].d2;
      assign pin = tap[k-1].p;
    end

    always_ff @(posedge clk)
      if (in_valid) begin
        d1 <= xin;
        d2 <= d1;
      end

    always_ff @(posedge clk)
      if (ce_in) a <= xin;

    if (IN_STAGE != 0) begin : g_opreg
      assign opnd = a;
    end else begin : g_opdir
      assign opnd = xin;
    end

    assign prod = opnd * $signed(coef[k]);

    always_ff @(posedge clk)
      if (in_valid) m <= prod;

    always_ff @(posedge clk)
      if (rst)           p <= '0;
      else if (in_valid) p <= pin + {{(AW-PW){m[PW-1]}}, m};
  end

  assign out_sample = tap[NTAPS-1].p;
endmodule

module fir_cascade_chk #(
  parameter int NTAPS = 4,
  parameter int CW    = 18,
  parameter int AW    = 48
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    coef_we,
  input logic                    out_valid,
  input logic [AW-1:0]           out_sample,
  input logic [NTAPS*CW-1:0]     coef_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_sample == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sample));

  // R3
  idle_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4
  valid_follows_adv_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R6
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_we && in_valid) |=> $stable(coef_flat));
endmodule

bind fir_cascade fir_cascade_chk #(.NTAPS(NTAPS), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .coef_we(coef_we),
  .out_valid(out_valid), .out_sample(out_sample), .coef_flat(coef)
);

// File: tb/fir_cascade_bench.sv
`timescale 1ns/1ps
module fir_cascade_bench;
  localparam int N = 4;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, coef_we = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic [2:0] coef_idx = '0;
  logic signed [17:0] coef_data = '0;
  logic v1, v0;
  logic signed [47:0] y1, y0;

  always #2.5 clk = ~clk;

  fir_cascade u_fir_cascade (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .out_valid(v1), .out_sample(y1));

  fir_cascade #(.IN_STAGE(0)) u_fir_cascade_nostage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .out_valid(v0), .out_sample(y0));

  localparam int SAMP [24] = '{5, -3, 12, 0, 100, -250, 7, 7, 1, -1, 2000, -32768,
                               32767, 44, -9, 300, 0, 0, 15, -600, 81, 3, -77, 1024};
  localparam int BIG [10] = '{32767, -32768, 32767, 32767, -32768, -32768, 32767, 1, -32768, 32767};

  int tests = 0, fails = 0, t = 0;
  longint xs [64];
  longint hh [64][N];
  longint hc [N];
  longint prev1, prev0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expy(int lat);
    longint s = 0;
    for (int j = 0; j < N; j++) s += hh[t-N+j][j] * xs[t-lat-j];
    return s;
  endfunction

  task automatic check_dut(input logic v, input logic signed [47:0] y, input int lat,
                           inout longint prev, input bit adv, input string ytag);
    bit ev;
    ev = adv && (t >= lat + N - 1);
    chk(v == ev, "R4 out_valid", longint'(v), longint'(ev));
    if (!adv) chk(longint'(y) == prev, "R3 hold", longint'(y), prev);
    else if (ev) chk(longint'(y) == expy(lat), ytag, longint'(y), expy(lat));
    prev = longint'(y);
  endtask

  task automatic cyc(input bit v, input int x, input bit we, input int idx, input int d, input string ytag);
    in_valid = v; in_sample = 16'(x); coef_we = we; coef_idx = 3'(idx); coef_data = 18'(d);
    if (v) begin
      xs[t] = x;
      for (int j = 0; j < N; j++) hh[t][j] = hc[j];
    end
    if (we && !v && idx < N) hc[idx] = longint'($signed(18'(d)));
    @(negedge clk);
    check_dut(v1, y1, N + 1, prev1, v, {ytag, " R2"});
    check_dut(v0, y0, N, prev0, v, {ytag, " R9"});
    if (v) t++;
    in_valid = 0; coef_we = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(v1 == 0 && y1 == 0, "R1 reset", longint'(y1), 0);
    chk(v0 == 0 && y0 == 0, "R1 reset nostage", longint'(y0), 0);
    prev1 = 0; prev0 = 0; t = 0;
  endtask

  initial begin
    for (int j = 0; j < N; j++) hc[j] = 0;
    @(negedge clk);
    do_reset();
    cyc(0, 0, 1, 0, 3, "R5");
    cyc(0, 0, 1, 1, -2, "R5");
    cyc(0, 0, 1, 2, 5, "R5");
    cyc(0, 0, 1, 3, 7, "R5");
    cyc(0, 0, 1, 5, 999, "R7");
    cyc(0, 0, 1, 4, -999, "R7");
    for (int i = 0; i < 24; i++) begin
      if (i == 12) cyc(1, SAMP[i], 1, 1, 12345, "R6");
      else         cyc(1, SAMP[i], 0, 0, 0, "main");
      if (i % 5 == 4) begin
        cyc(0, 0, 0, 0, 0, "idle");
        cyc(0, 0, 0, 0, 0, "idle");
      end
      if (i == 17) cyc(0, 0, 1, 1, -40, "R5 midstream");
    end
    cyc(0, 0, 1, 0, 131071, "R10");
    cyc(0, 0, 1, 2, -131072, "R10");
    cyc(0, 0, 1, 3, 131071, "R10");
    for (int i = 0; i < 10; i++) cyc(1, BIG[i], 0, 0, 0, "R10");
    cyc(1, 5, 0, 0, 0, "R10");
    do_reset();
    for (int i = 0; i < 12; i++) cyc(1, SAMP[i], 0, 0, 0, "R8");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule